// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block receives asynchronous serial bytes framed as one low start bit, eight data bits sent least significant bit first, no parity bit and one high stop bit. The clock runs at eight times the bit rate. The raw line first passes through a two-flop synchronizer. A pair of registered "line low" flags then detects the falling edge that opens a frame, and that edge starts a single frame counter.

A fixed decoder compares the counter against a list of eight count values, spaced one bit time apart. Each match is a one-clock sample strike that shifts the synchronized line level into the top of a shift register, so the register moves right. The start bit itself is never stored. Two more points on the same counter decide how a frame ends. A line that is high again early in the start bit marks a glitch, and the frame is abandoned. A high stop bit releases the byte to the output with a one-clock valid pulse.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `data_o` is 0 and `valid_o` is low, and `valid_o` stays low while `rx_i` idles high.
- R2: A well-formed frame yields `data_o[i]` equal to the i-th data bit after the start bit (bit 0 arrives first).
- R3: `valid_o` is high for exactly one clock. It rises on the 77th rising edge of `clk_i`, counting as the 1st the edge that first captures the start bit's low level on `rx_i`.
- R4: Frames sent back to back, with each stop bit followed at once by the next start bit, each produce exactly one valid pulse with the correct byte.
- R5: The receiver abandons the frame and produces no byte if `rx_i` is high at the 6th edge of the start bit. With a start level low for 5 or fewer edges, nothing is produced. With a start level low for 6 or more edges, the frame proceeds.
- R6: A stop bit sampled low produces no valid pulse, and `data_o` keeps its previous byte.
- R7: Only a falling transition on the line opens a frame. A line held low after a failed frame produces nothing. Once the line returns high, the next frame is received.
- R8: Each data bit and the stop bit are taken from the `rx_i` value captured at the 3rd edge of that bit's eight-clock bit time. Line levels at any other edge of the bit have no effect.
- R9: `data_o` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, eight times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last byte received |
| valid_o | output | 1 | One-clock pulse when `data_o` is updated |

## Verification
Every stimulus is placed in slots of one clock, and eight slots make one bit time. The first slot of a frame drives the start level. Two synchronizer flops, the edge flags and the counter put the valid pulse on the 77th edge after that slot (slot index + 77). The bench records the cycle of each pulse and compares it with that figure exactly.

Sample-point checks drive each data bit correctly only in slot 2 of its bit time and inverted elsewhere, so a shifted strike list corrupts the byte. Glitch checks place the return to high on either side of slot 5 of the start bit.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;

  function automatic int unsigned last_count(int unsigned first, int unsigned osr,
                                             int unsigned bits);
    return first + osr * bits;
  endfunction
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_timer.sv
module uart_os_rx_timer
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned OSR       = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FIRST_AT  = 9,
  parameter int unsigned GLITCH_AT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic strike_o,
  output logic done_o
);
  localparam int unsigned STOP_AT_I = last_count(FIRST_AT, OSR, DATA_W);
  localparam int unsigned CNT_W     = $clog2(STOP_AT_I + 1);
  localparam logic [CNT_W-1:0] STOP_AT   = CNT_W'(STOP_AT_I);
  localparam logic [CNT_W-1:0] GLITCH_C  = CNT_W'(GLITCH_AT);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             low_now_q, low_prev_q;
  logic             start_w, glitch_w, stop_w;
  logic [DATA_W-1:0] hit_w;

  // edge flags: line low now, line low one clock earlier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_now_q  <= 1'b0;
      low_prev_q <= 1'b0;
    end else begin
      low_now_q  <= ~line_i;
      low_prev_q <= low_now_q;
    end
  end

  assign start_w  = (state_q == RX_IDLE) & low_now_q & ~low_prev_q;
  assign glitch_w = (state_q == RX_BUSY) & (cnt_q == GLITCH_C) & line_i;
  assign stop_w   = (state_q == RX_BUSY) & (cnt_q == STOP_AT);

  for (genvar k = 0; k < DATA_W; k++) begin : g_strike
    localparam logic [CNT_W-1:0] AT = CNT_W'(FIRST_AT + k * OSR);
    assign hit_w[k] = (cnt_q == AT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else if (start_w) begin
      state_q <= RX_BUSY;
      cnt_q   <= CNT_W'(1);
    end else if (state_q == RX_BUSY) begin
      if (glitch_w || stop_w) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign strike_o = (state_q == RX_BUSY) & (|hit_w);
  assign done_o   = stop_w & line_i;

  AST_GLITCH_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_w |=> (state_q == RX_IDLE)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_BUSY) |-> (cnt_q <= STOP_AT)); // R4
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == RX_IDLE && cnt_q == '0)); // R4
  AST_STRIKE_NOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strike_o |-> (cnt_q > GLITCH_C)); // R8
endmodule

// File: rtl/uart_os_rx_shift.sv
module uart_os_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              strike_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] shift_q, data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (strike_i) shift_q <= {line_i, shift_q[DATA_W-1:1]}; // LSB arrives first
      if (done_i)   data_q  <= shift_q;
      valid_q <= done_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R3
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q)); // R9
  AST_NO_STRIKE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strike_i && done_i)); // R2
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int unsigned OSR         = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FIRST_AT    = 9,
  parameter int unsigned GLITCH_AT   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic line_s, strike_w, done_w;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line_s)
  );

  uart_os_rx_timer #(
    .OSR      (OSR),
    .DATA_W   (DATA_W),
    .FIRST_AT (FIRST_AT),
    .GLITCH_AT(GLITCH_AT)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_s),
    .strike_o(strike_w),
    .done_o  (done_w)
  );

  uart_os_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_s),
    .strike_i(strike_w),
    .done_i  (done_w),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
  localparam int LAT = 77;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] data_o;
  logic       valid_o;

  int cyc = 0, n_tests = 0, n_fail = 0;
  int vcount = 0, vcyc = 0;
  logic [7:0] vdata = 8'h00;
  logic       valid_prev = 1'b0;

  always #2 clk = ~clk;

  uart_os_rx dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        vcount = vcount + 1;
        vcyc   = cyc;
        vdata  = data_o;
        if (valid_prev) begin
          n_fail++;
          $display("FAIL R3 pulse width: actual >1 cycle expected 1 cycle");
        end
      end
      valid_prev = valid_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic idle(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_i = v;
    end
  endtask

  // one frame as 80 one-clock slots; smear: data valid only in slot 2 of each bit
  task automatic send_frame(input logic [7:0] d, input int start_len, input logic stop_v,
                            input bit smear, output int s);
    logic b;
    s = 0;
    for (int slot = 0; slot < 80; slot++) begin
      @(negedge clk);
      if (slot == 0) s = cyc;
      if (slot < 8) rx_i = (slot < start_len) ? 1'b0 : 1'b1;
      else if (slot < 72) begin
        b = d[(slot - 8) / 8];
        rx_i = (smear && (slot % 8) != 2) ? ~b : b;
      end else rx_i = stop_v;
    end
  endtask

  task automatic expect_byte(input string req, input logic [7:0] d, input int s, input int n0);
    check({req, " pulse count"}, vcount, n0 + 1);
    check({req, " pulse cycle"}, vcyc - s, LAT);
    check({req, " data"}, int'(vdata), int'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog: actual %0d cycles expected completion earlier", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s, n0;
    logic [7:0] last;
    repeat (4) @(negedge clk);
    check("R1 reset data_o", int'(data_o), 0);
    check("R1 reset valid_o", int'(valid_o), 0);
    rst_ni = 1'b1;
    idle(40, 1'b1);
    check("R1 idle no pulse", vcount, 0);

    // R2 R3 R4: all bytes back to back, clean bits
    for (int v = 0; v < 256; v++) begin
      n0 = vcount;
      send_frame(8'(v), 8, 1'b1, 1'b0, s);
      expect_byte("R2 R4 sweep", 8'(v), s, n0);
    end
    idle(16, 1'b1);

    // R8: each data bit correct only in its third slot
    for (int v = 0; v < 256; v++) begin
      n0 = vcount;
      send_frame(8'(v ^ 8'h5A), 8, 1'b1, 1'b1, s);
      expect_byte("R8 sample point", 8'(v ^ 8'h5A), s, n0);
    end
    idle(16, 1'b1);

    // R9: output holds through idle
    last = vdata;
    idle(50, 1'b1);
    check("R9 data hold", int'(data_o), int'(last));

    // R5: glitch boundary
    for (int len = 1; len <= 5; len++) begin
      n0 = vcount;
      send_frame(8'hFF, len, 1'b1, 1'b0, s);
      idle(8, 1'b1);
      check("R5 short start no byte", vcount, n0);
    end
    n0 = vcount;
    send_frame(8'hFF, 6, 1'b1, 1'b0, s);
    expect_byte("R5 six-slot start", 8'hFF, s, n0);
    idle(8, 1'b1);
    n0 = vcount;
    send_frame(8'h81, 8, 1'b1, 1'b0, s);
    expect_byte("R5 after glitch", 8'h81, s, n0);

    // R6: low stop bit
    last = vdata;
    n0 = vcount;
    send_frame(8'h3C, 8, 1'b0, 1'b0, s);
    check("R6 bad stop no pulse", vcount, n0);
    check("R6 bad stop data kept", int'(data_o), int'(last));

    // R7: held low yields nothing; recovers after high
    idle(120, 1'b0);
    check("R7 held low no pulse", vcount, n0);
    idle(16, 1'b1);
    n0 = vcount;
    send_frame(8'hC3, 8, 1'b1, 1'b0, s);
    expect_byte("R7 recovery", 8'hC3, s, n0);
    idle(8, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule